// File: doc/BRIEF.md
# Opcode-Decoded Logical Shift Unit

This execution unit performs logical left and right shifts for a byte-coded instruction. It takes the primary opcode byte and the 3-bit reg field of the addressing byte. From these it picks the shift direction, the source of the shift count and the operand width. The count can be the constant one, the value of an 8-bit count register, or an 8-bit immediate. Bits moved into the operand are always zeros. The unit also returns the last bit that was shifted out as a carry flag.

The unit has a single register stage. Inputs qualified by `valid_i` appear on the outputs one clock later. Only the low five bits of the selected count are used. This holds for 8-, 16- and 32-bit operands alike, so a narrow operand can be shifted past its own width. Unsupported encodings are flagged, not shifted. For narrow operations the bits of the 32-bit bus above the operand pass through unchanged, so the result can be written back to a full register.

Top module: `shift_exec`

## Requirements
- R1: Vacated bit positions are filled with zeros in both directions; no sign bit is copied.
- R2: A reg field of 4 selects a left shift and a reg field of 5 selects a right shift.
- R3: Opcodes 0xD0 and 0xD1 shift by a constant count of one.
- R4: Opcodes 0xD2 and 0xD3 take the count from `count_i`.
- R5: Opcodes 0xC0 and 0xC1 take the count from `imm_i`.
- R6: Opcodes with bit 0 clear (0xD0, 0xD2, 0xC0) act on bits [7:0]. Opcodes with bit 0 set act on bits [15:0] when `opsz32_i` is 0 and on bits [31:0] when it is 1.
- R7: Only bits [4:0] of the selected count are used, so a count of 33 shifts by one.
- R8: For 8- and 16-bit operations, a masked count equal to or larger than the width clears the whole operand field.
- R9: For a nonzero masked count, `cf_o` is the last bit shifted out of the original operand (0 when the count exceeds the width) and `cf_upd_o` is 1.
- R10: For a masked count of zero, `result_o` equals the operand and both `cf_upd_o` and `cf_o` are 0.
- R11: Any opcode other than the six above, or a reg field other than 4 or 5, gives `illegal_o`=1 with `result_o` equal to the operand and `cf_upd_o`=`cf_o`=0.
- R12: For 8- and 16-bit operations, the result bits above the operand width equal the input operand bits.
- R13: Outputs update one clock after a cycle with `valid_i`=1, and `valid_o` follows `valid_i` with one cycle of delay. While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Primary opcode byte |
| modrm_reg_i | input | 3 | Reg field of the addressing byte |
| opsz32_i | input | 1 | 1 selects 32-bit, 0 selects 16-bit for wide opcodes |
| operand_i | input | 32 | Destination operand value |
| count_i | input | 8 | Count register value |
| imm_i | input | 8 | Immediate count byte |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Encoding not supported |
| result_o | output | 32 | Shifted result |
| cf_o | output | 1 | Last bit shifted out |
| cf_upd_o | output | 1 | Carry flag should be written |

## Verification
Count masking and the over-width clearing rule can apply to the same instruction. For example, a count of 40 on an 8-bit operand is first reduced to 8 and then clears the byte, with the carry taken from bit 0 (left) or bit 7 (right). The bench provokes this with directed counts of 8, 16, 33 and 40 through both the count register and the immediate, and with random 8-bit counts. Each result is judged against a bench model that applies the mask first and the width rule second. The same model also checks the passthrough of the upper bits in the same cycle.

// File: rtl/shift_exec_pkg.sv
package shift_exec_pkg;
  typedef enum logic [1:0] {SRC_ONE = 2'd0, SRC_REG = 2'd1, SRC_IMM = 2'd2} cnt_src_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2} op_size_e;
  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/shift_exec_decode.sv
module shift_exec_decode
  import shift_exec_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [2:0] reg_i,
  input  logic       opsz32_i,
  output logic       legal_o,
  output logic       left_o,
  output cnt_src_e   src_o,
  output op_size_e   size_o
);
  logic op_ok;

  always_comb begin
    op_ok = 1'b1;
    src_o = SRC_ONE;
    unique case (opcode_i[7:1])
      7'h68:   src_o = SRC_ONE;
      7'h69:   src_o = SRC_REG;
      7'h60:   src_o = SRC_IMM;
      default: op_ok = 1'b0;
    endcase
  end

  // R2
  assign left_o  = (reg_i == 3'd4);
  assign legal_o = op_ok && (reg_i == 3'd4 || reg_i == 3'd5);
  // R6
  assign size_o  = !opcode_i[0] ? SZ_B : (opsz32_i ? SZ_D : SZ_W);
endmodule

// File: rtl/shift_exec_count.sv
module shift_exec_count
  import shift_exec_pkg::*;
#(
  parameter int unsigned RAW_W = 8,
  parameter int unsigned CNT_W = 5
) (
  input  cnt_src_e         src_i,
  input  logic [RAW_W-1:0] count_i,
  input  logic [RAW_W-1:0] imm_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [RAW_W-1:0] raw;
  logic [RAW_W-CNT_W-1:0] unused_hi;

  always_comb begin
    unique case (src_i)
      SRC_REG: raw = count_i;
      SRC_IMM: raw = imm_i;
      default: raw = RAW_W'(1);
    endcase
  end

  // R7: only the low bits survive
  assign cnt_o     = raw[CNT_W-1:0];
  assign unused_hi = raw[RAW_W-1:CNT_W];
endmodule

// File: rtl/shift_exec_lane.sv
module shift_exec_lane #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             left_i,
  output logic [XLEN-1:0]  y_o,
  output logic             cf_o
);
  logic [W:0] lext;
  logic [W:0] rext;

  // extra bit catches the last bit out; counts past W leave only zeros (R8)
  assign lext = {1'b0, a_i[W-1:0]} << n_i;
  assign rext = {a_i[W-1:0], 1'b0} >> n_i;

  always_comb begin
    y_o = a_i; // R12: bits above W pass through
    if (left_i) begin
      y_o[W-1:0] = lext[W-1:0];
      cf_o       = lext[W];
    end else begin
      y_o[W-1:0] = rext[W:1];
      cf_o       = rext[0];
    end
  end
endmodule

// File: rtl/shift_exec_core.sv
module shift_exec_core
  import shift_exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned CNT_W = 5
) (
  input  logic [XLEN-1:0]  a_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic             left_i,
  input  op_size_e         size_i,
  output logic [XLEN-1:0]  y_o,
  output logic             cf_o
);
  logic [XLEN-1:0] lane_y  [NUM_SIZES];
  logic            lane_cf [NUM_SIZES];

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
    shift_exec_lane #(.XLEN(XLEN), .W(8 << i), .CNT_W(CNT_W)) u_lane (
      .a_i   (a_i),
      .n_i   (n_i),
      .left_i(left_i),
      .y_o   (lane_y[i]),
      .cf_o  (lane_cf[i])
    );
  end

  always_comb begin
    unique case (size_i)
      SZ_W:    begin y_o = lane_y[1]; cf_o = lane_cf[1]; end
      SZ_D:    begin y_o = lane_y[2]; cf_o = lane_cf[2]; end
      default: begin y_o = lane_y[0]; cf_o = lane_cf[0]; end
    endcase
  end
endmodule

// File: rtl/shift_exec.sv
module shift_exec
  import shift_exec_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned RAW_W = 8,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       opcode_i,
  input  logic [2:0]       modrm_reg_i,
  input  logic             opsz32_i,
  input  logic [XLEN-1:0]  operand_i,
  input  logic [RAW_W-1:0] count_i,
  input  logic [RAW_W-1:0] imm_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [XLEN-1:0]  result_o,
  output logic             cf_o,
  output logic             cf_upd_o
);
  logic             legal, left;
  cnt_src_e         src;
  op_size_e         size;
  logic [CNT_W-1:0] cnt;
  logic [XLEN-1:0]  sh_y;
  logic             sh_cf;
  logic             do_shift;

  shift_exec_decode u_dec (
    .opcode_i(opcode_i),
    .reg_i   (modrm_reg_i),
    .opsz32_i(opsz32_i),
    .legal_o (legal),
    .left_o  (left),
    .src_o   (src),
    .size_o  (size)
  );

  shift_exec_count #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_cnt (
    .src_i  (src),
    .count_i(count_i),
    .imm_i  (imm_i),
    .cnt_o  (cnt)
  );

  shift_exec_core #(.XLEN(XLEN), .CNT_W(CNT_W)) u_core (
    .a_i   (operand_i),
    .n_i   (cnt),
    .left_i(left),
    .size_i(size),
    .y_o   (sh_y),
    .cf_o  (sh_cf)
  );

  // R10, R11: zero count or bad encoding leaves operand and flags alone
  assign do_shift = legal && (cnt != '0);

  // R13
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      cf_o      <= 1'b0;
      cf_upd_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= !legal;
        result_o  <= do_shift ? sh_y : operand_i;
        cf_o      <= do_shift && sh_cf;
        cf_upd_o  <= do_shift;
      end
    end
  end

  // R13
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R11
  bad_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && modrm_reg_i != 3'd4 && modrm_reg_i != 3'd5 |=> illegal_o && !cf_upd_o);

  // R10
  no_upd_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (cf_upd_o || (result_o == $past(operand_i) && !cf_o)));

  // R12
  byte_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !opcode_i[0] |=> result_o[XLEN-1:8] == $past(operand_i[XLEN-1:8]));

  // R3
  by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:1] == 7'h68 && (modrm_reg_i == 3'd4 || modrm_reg_i == 3'd5)
    |=> cf_upd_o && !illegal_o);
endmodule

// File: tb/sim_shift_exec.sv
module sim_shift_exec;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [2:0]  modrm_reg_i = '0;
  logic        opsz32_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic [7:0]  imm_i = '0;
  logic        valid_o, illegal_o, cf_o, cf_upd_o;
  logic [31:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  shift_exec u0 (.*);

  function automatic void model(input logic [7:0] op, input logic [2:0] rg, input logic s32,
                                input logic [31:0] a, input logic [7:0] c, input logic [7:0] im,
                                output logic [31:0] y, output logic cf, output logic upd,
                                output logic ill);
    logic [7:0] raw;
    int n, w;
    logic [63:0] mask, fld, s;
    ill = !((op[7:1] == 7'h68 || op[7:1] == 7'h69 || op[7:1] == 7'h60) && (rg == 3'd4 || rg == 3'd5));
    y = a; cf = 1'b0; upd = 1'b0;
    if (ill) return;
    raw = (op[7:1] == 7'h68) ? 8'd1 : (op[7:1] == 7'h69) ? c : im;
    n = int'(raw[4:0]);
    if (n == 0) return;
    w = !op[0] ? 8 : (s32 ? 32 : 16);
    mask = (64'd1 << w) - 64'd1;
    fld = {32'd0, a} & mask;
    if (rg == 3'd4) begin
      s = fld << n;
      cf = s[w];
      s = s & mask;
    end else begin
      cf = fld[n-1 +: 1] == 1'b1 && n <= w;
      s = fld >> n;
    end
    y = (a & ~mask[31:0]) | s[31:0];
    upd = 1'b1;
  endfunction

  task automatic apply(input string tag, input logic [7:0] op, input logic [2:0] rg,
                       input logic s32, input logic [31:0] a, input logic [7:0] c,
                       input logic [7:0] im);
    logic [31:0] ey;
    logic ecf, eupd, eill;
    model(op, rg, s32, a, c, im, ey, ecf, eupd, eill);
    opcode_i = op; modrm_reg_i = rg; opsz32_i = s32;
    operand_i = a; count_i = c; imm_i = im; valid_i = 1'b1;
    @(negedge clk_i);
    n_vec++;
    if (valid_o !== 1'b1 || illegal_o !== eill || result_o !== ey ||
        cf_o !== ecf || cf_upd_o !== eupd) begin
      n_bad++;
      $display("FAIL %s op=%h reg=%0d c=%h im=%h a=%h: got v=%b ill=%b y=%h cf=%b upd=%b exp v=1 ill=%b y=%h cf=%b upd=%b",
               tag, op, rg, c, im, a, valid_o, illegal_o, result_o, cf_o, cf_upd_o,
               eill, ey, ecf, eupd);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [6];
    ops = '{8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hC0, 8'hC1};
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk_i);
    // R13: reset state
    n_vec++;
    if (valid_o !== 1'b0 || illegal_o !== 1'b0 || result_o !== 32'd0 || cf_o !== 1'b0 || cf_upd_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 reset: got v=%b ill=%b y=%h exp zeros", valid_o, illegal_o, result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 zero fill, both directions, top bit set
    apply("R1_left",  8'hD1, 3'd4, 1'b1, 32'hF000_0001, 8'd0, 8'd0);
    apply("R1_right", 8'hD1, 3'd5, 1'b1, 32'h8000_0001, 8'd0, 8'd0);
    apply("R2_right_byte", 8'hD0, 3'd5, 1'b0, 32'hABCD_EF81, 8'd0, 8'd0);
    // R3 R4 R5 count sources
    apply("R3_one", 8'hD0, 3'd4, 1'b0, 32'h0000_00C3, 8'd7, 8'd7);
    apply("R4_reg", 8'hD3, 3'd4, 1'b0, 32'h1234_00FF, 8'd4, 8'd9);
    apply("R5_imm", 8'hC1, 3'd5, 1'b1, 32'hDEAD_BEEF, 8'd2, 8'd12);
    // R7 masking: 33 acts as 1, 32 acts as 0
    apply("R7_imm33", 8'hC1, 3'd4, 1'b1, 32'h8000_0003, 8'd0, 8'd33);
    apply("R7_reg32", 8'hD3, 3'd5, 1'b1, 32'h8765_4321, 8'd32, 8'd0);
    // R8 over-width combined with masking
    apply("R8_byte8",   8'hD2, 3'd4, 1'b0, 32'h5555_55FF, 8'd8, 8'd0);
    apply("R8_byte40",  8'hC0, 3'd5, 1'b0, 32'h5555_5580, 8'd0, 8'd40);
    apply("R8_word16",  8'hD3, 3'd5, 1'b0, 32'hAAAA_8001, 8'd16, 8'd0);
    apply("R8_word20",  8'hC1, 3'd4, 1'b0, 32'hAAAA_FFFF, 8'd0, 8'd20);
    // R9 carry at full width
    apply("R9_d31_left",  8'hD3, 3'd4, 1'b1, 32'h0000_0001, 8'd31, 8'd0);
    apply("R9_d31_right", 8'hD3, 3'd5, 1'b1, 32'h8000_0000, 8'd31, 8'd0);
    // R10 zero count
    apply("R10_zero", 8'hC0, 3'd4, 1'b0, 32'h0102_0304, 8'd0, 8'd0);
    // R11 illegal encodings
    apply("R11_op",  8'hD4, 3'd4, 1'b0, 32'h1111_2222, 8'd3, 8'd3);
    apply("R11_reg", 8'hD1, 3'd6, 1'b1, 32'h3333_4444, 8'd3, 8'd3);
    apply("R11_reg7", 8'hC0, 3'd7, 1'b0, 32'h3333_4444, 8'd3, 8'd3);
    // R12 upper passthrough
    apply("R12_word", 8'hD1, 3'd4, 1'b0, 32'hCAFE_8000, 8'd0, 8'd0);

    // R13 valid drop
    valid_i = 1'b0;
    @(negedge clk_i);
    n_vec++;
    if (valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R13 valid drop: got %b exp 0", valid_o);
    end

    // R6 and the rest: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      logic [2:0] rg;
      op = ($urandom_range(0, 15) == 0) ? 8'($urandom) : ops[$urandom_range(0, 5)];
      rg = ($urandom_range(0, 9) == 0) ? 3'($urandom) : (($urandom_range(0, 1) == 1) ? 3'd4 : 3'd5);
      apply("R6_rand", op, rg, 1'($urandom), $urandom, 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule